// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block gathers fault indications from around the chip and decides, for each PWM channel pair, whether that pair's outputs must be forced into their safe state. The inputs are two analog comparator outputs, two external brake pins, an ADC result-monitor flag, four system failure flags and per-pair software requests. The system failure flags are clock-security failure, brown-out, SRAM parity error and core lockup. The brake pins first pass through a polarity inverter and an optional digital noise filter. The filter samples on a divided clock tick and takes a new pin level only once that level has persisted for a programmed number of ticks.

Each source has two enables. The latched (edge) enable makes a rising source set a per-pair edge flag, which holds until software clears it. The live (level) enable makes the active source hold the per-pair level flag. The level flag is released only at that pair's next PWM period boundary after every enabled level source has gone inactive. A pair brakes whenever either flag is set. Each brake-active bit is copied onto a two-bit output mask that covers both channels of the pair. A one-cycle interrupt pulse marks any flag being newly raised.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: After reset, edge_flag, level_flag, brake_active, out_mask and brake_irq are all zero.
- R2: A 0-to-1 change on a source whose bit in edge_en is set raises edge_flag of every pair after one clock edge. The source bit order is 0 comparator 0, 1 comparator 1, 2 filtered pin 0, 3 filtered pin 1, 4 ADC monitor, 5 system fail. The flag stays set after the source returns low.
- R3: A high edge_clr[p] clears edge_flag[p] on the next edge and no other pair's flag. When a set condition arrives in the same cycle as the clear, the set condition wins.
- R4: Whenever a source is high and its level_en bit is set, level_flag of every pair is set on the next edge. Once no level source is active, level_flag[p] falls only at an edge where period_end[p] is high. While a level source is still active, period_end leaves the flag set.
- R5: A source whose enable bits are both clear has no effect on either flag. A source enabled only on one path affects only that path's flag.
- R6: sys_sel[i] gates sys_fail[i] into the system source, with bit 0 clock-security failure, bit 1 brown-out, bit 2 SRAM parity and bit 3 core lockup. An unselected failure has no effect.
- R7: sw_edge_req[p] sets edge_flag[p] only, and sw_level_req[p] acts as a level source for pair p only.
- R8: pin_invert[i] inverts brake pin i before the filter, so a low pin counts as active when the bit is set.
- R9: With filt_en high, the filter samples once every 2^filt_div clocks (filt_div 0..7 gives 1..128). A new pin level is accepted on the filt_thr-th consecutive sampled tick that differs, with 0 treated as 1. A pulse shorter than that is ignored. With filt_en low, the pin level passes after one register.
- R10: brake_active[p] is edge_flag[p] OR level_flag[p], and out_mask bits 2p and 2p+1 both equal brake_active[p].
- R11: brake_irq is high for exactly the cycle in which some flag changes from 0 to 1, and does not repeat while flags only stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 2 | Comparator outputs 1 and 0 |
| brk_pin | input | 2 | External brake pins |
| adc_mon | input | 1 | ADC result-monitor flag |
| sys_fail | input | 4 | System failure flags |
| sys_sel | input | 4 | Selects which system failures count |
| edge_en | input | 6 | Latched path enable per source |
| level_en | input | 6 | Live path enable per source |
| pin_invert | input | 2 | Per-pin input inversion |
| filt_en | input | 1 | Noise filter enable |
| filt_div | input | 3 | Filter sample tick divider code |
| filt_thr | input | FILT_CNT_W | Consecutive ticks needed to accept a level |
| sw_edge_req | input | N_PAIRS | Software latched brake request per pair |
| sw_level_req | input | N_PAIRS | Software live brake request per pair |
| edge_clr | input | N_PAIRS | Clear for the per-pair edge flag |
| period_end | input | N_PAIRS | PWM period boundary strobe per pair |
| edge_flag | output | N_PAIRS | Latched brake status |
| level_flag | output | N_PAIRS | Live brake status |
| brake_active | output | N_PAIRS | Pair is braked |
| out_mask | output | 2*N_PAIRS | Per-channel brake mask |
| brake_irq | output | 1 | One-cycle pulse on a new brake |

## Verification
Two collisions are provoked deliberately. The first drives a software clear of the edge flag in the same cycle as a fresh latched request for that pair, and the flag is expected set afterwards. The second pulses the period boundary while a level source is still active, and the level flag is expected to remain set. In both cases the bench samples the flags one edge after the collision and compares the three pairs individually. This shows that the untouched pairs are not disturbed either.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;
  localparam int SRC_N     = 6;
  localparam int SRC_CMP0  = 0;
  localparam int SRC_CMP1  = 1;
  localparam int SRC_PIN0  = 2;
  localparam int SRC_PIN1  = 3;
  localparam int SRC_ADC   = 4;
  localparam int SRC_SYS   = 5;
  localparam int SYS_N     = 4;
  localparam int PIN_N     = 2;
  localparam int DIV_SEL_W = 3;
  localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;

  // low bits of the free-running counter that must all be one for a tick
  function automatic logic [DIV_CNT_W-1:0] div_mask(input logic [DIV_SEL_W-1:0] sel);
    logic [DIV_CNT_W:0] one;
    one = 1;
    return DIV_CNT_W'((one << sel) - 1'b1);
  endfunction

  // true when this differing tick completes the required run
  function automatic logic filt_reached(input int unsigned cnt, input int unsigned thr);
    return (cnt + 1) >= thr;
  endfunction
endpackage

// File: rtl/brake_tick_gen.sv
module brake_tick_gen
  import pwm_brake_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] mask;

  assign mask = div_mask(div_sel);
  assign tick = (cnt_q & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/brake_pin_filter.sv
module brake_pin_filter
  import pwm_brake_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             invert,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] thr,
  output logic             level
);
  logic             raw;
  logic [CNT_W-1:0] run_q;

  assign raw = pin ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      run_q <= '0;
    end else if (!en) begin
      level <= raw;
      run_q <= '0;
    end else if (tick) begin
      if (raw == level) begin
        run_q <= '0;
      end else if (filt_reached(32'(run_q), 32'(thr))) begin
        level <= raw;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brake_pair_ctrl.sv
module brake_pair_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hit,
  input  logic lvl_hit,
  input  logic sw_edge,
  input  logic sw_lvl,
  input  logic clr,
  input  logic period_end,
  output logic edge_q,
  output logic lvl_q,
  output logic new_evt
);
  logic edge_set;
  logic lvl_now;

  assign edge_set = edge_hit | sw_edge;
  assign lvl_now  = lvl_hit | sw_lvl;
  assign new_evt  = (edge_set & ~edge_q) | (lvl_now & ~lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (edge_set)  edge_q <= 1'b1;
      else if (clr)  edge_q <= 1'b0;
      if (lvl_now)         lvl_q <= 1'b1;
      else if (period_end) lvl_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_brake_ctrl.sv
module pwm_brake_ctrl
  import pwm_brake_pkg::*;
#(
  parameter int N_PAIRS    = 3,
  parameter int FILT_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cmp_in,
  input  logic [PIN_N-1:0]      brk_pin,
  input  logic                  adc_mon,
  input  logic [SYS_N-1:0]      sys_fail,
  input  logic [SYS_N-1:0]      sys_sel,
  input  logic [SRC_N-1:0]      edge_en,
  input  logic [SRC_N-1:0]      level_en,
  input  logic [PIN_N-1:0]      pin_invert,
  input  logic                  filt_en,
  input  logic [DIV_SEL_W-1:0]  filt_div,
  input  logic [FILT_CNT_W-1:0] filt_thr,
  input  logic [N_PAIRS-1:0]    sw_edge_req,
  input  logic [N_PAIRS-1:0]    sw_level_req,
  input  logic [N_PAIRS-1:0]    edge_clr,
  input  logic [N_PAIRS-1:0]    period_end,
  output logic [N_PAIRS-1:0]    edge_flag,
  output logic [N_PAIRS-1:0]    level_flag,
  output logic [N_PAIRS-1:0]    brake_active,
  output logic [2*N_PAIRS-1:0]  out_mask,
  output logic                  brake_irq
);
  localparam int MASK_W = 2 * N_PAIRS;

  logic               filt_tick;
  logic [PIN_N-1:0]   pin_f;
  logic               sys_hit;
  logic [SRC_N-1:0]   src;
  logic [SRC_N-1:0]   src_q;
  logic               ev_edge_hit;
  logic               ev_lvl_hit;
  logic [N_PAIRS-1:0] ev_new;

  brake_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (filt_div),
    .tick    (filt_tick)
  );

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    brake_pin_filter #(.CNT_W(FILT_CNT_W)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (brk_pin[i]),
      .invert (pin_invert[i]),
      .en     (filt_en),
      .tick   (filt_tick),
      .thr    (filt_thr),
      .level  (pin_f[i])
    );
  end

  assign sys_hit = |(sys_fail & sys_sel);

  always_comb begin
    src           = '0;
    src[SRC_CMP0] = cmp_in[0];
    src[SRC_CMP1] = cmp_in[1];
    src[SRC_PIN0] = pin_f[0];
    src[SRC_PIN1] = pin_f[1];
    src[SRC_ADC]  = adc_mon;
    src[SRC_SYS]  = sys_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src;
  end

  assign ev_edge_hit = |(edge_en & src & ~src_q);
  assign ev_lvl_hit  = |(level_en & src);

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    brake_pair_ctrl u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_hit   (ev_edge_hit),
      .lvl_hit    (ev_lvl_hit),
      .sw_edge    (sw_edge_req[p]),
      .sw_lvl     (sw_level_req[p]),
      .clr        (edge_clr[p]),
      .period_end (period_end[p]),
      .edge_q     (edge_flag[p]),
      .lvl_q      (level_flag[p]),
      .new_evt    (ev_new[p])
    );
    assign brake_active[p]   = edge_flag[p] | level_flag[p];
    assign out_mask[2*p]     = brake_active[p];
    assign out_mask[2*p + 1] = brake_active[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brake_irq <= 1'b0;
    else        brake_irq <= |ev_new;
  end

  logic [MASK_W-1:0] unused_width_chk;
  assign unused_width_chk = out_mask;
endmodule

// File: rtl/pwm_brake_chk.sv
module pwm_brake_chk #(
  parameter int N_PAIRS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PAIRS-1:0] edge_flag,
  input logic [N_PAIRS-1:0] level_flag,
  input logic [N_PAIRS-1:0] edge_clr,
  input logic [N_PAIRS-1:0] period_end,
  input logic [N_PAIRS-1:0] sw_level_req,
  input logic               brake_irq,
  input logic               filt_en,
  input logic               filt_tick,
  input logic [1:0]         pin_f,
  input logic               ev_edge_hit
);
  // R2: a latched flag only drops where its clear was requested
  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_flag) & ~$past(edge_clr) & ~edge_flag) == '0));

  // R2: an enabled rising source latches every pair
  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge_hit |=> (edge_flag == '1));

  // R4: a live flag only falls at a period boundary
  p_level_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(level_flag) & ~level_flag & ~$past(period_end)) == '0));

  // R7: a software live request on pair 0 holds that pair's flag
  p_sw_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_level_req[0] |=> level_flag[0]);

  // R9: the filtered pin changes only on a sample tick
  p_filter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !filt_tick) |=> $stable(pin_f));

  // R11: the interrupt only accompanies a raised flag
  p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brake_irq |-> ((edge_flag | level_flag) != '0));
endmodule

bind pwm_brake_ctrl pwm_brake_chk #(.N_PAIRS(N_PAIRS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .edge_flag    (edge_flag),
  .level_flag   (level_flag),
  .edge_clr     (edge_clr),
  .period_end   (period_end),
  .sw_level_req (sw_level_req),
  .brake_irq    (brake_irq),
  .filt_en      (filt_en),
  .filt_tick    (filt_tick),
  .pin_f        (pin_f),
  .ev_edge_hit  (ev_edge_hit)
);

// File: tb/pwm_brake_ctrl_tb.sv
module pwm_brake_ctrl_tb;
  localparam int NP = 3;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmp_in = '0;
  logic [1:0]    brk_pin = '0;
  logic          adc_mon = 1'b0;
  logic [3:0]    sys_fail = '0;
  logic [3:0]    sys_sel = '0;
  logic [5:0]    edge_en = '0;
  logic [5:0]    level_en = '0;
  logic [1:0]    pin_invert = '0;
  logic          filt_en = 1'b0;
  logic [2:0]    filt_div = '0;
  logic [TW-1:0] filt_thr = '0;
  logic [NP-1:0] sw_edge_req = '0;
  logic [NP-1:0] sw_level_req = '0;
  logic [NP-1:0] edge_clr = '0;
  logic [NP-1:0] period_end = '0;
  logic [NP-1:0] edge_flag, level_flag, brake_active;
  logic [2*NP-1:0] out_mask;
  logic          brake_irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pwm_brake_ctrl #(.N_PAIRS(NP), .FILT_CNT_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .brk_pin(brk_pin),
    .adc_mon(adc_mon), .sys_fail(sys_fail), .sys_sel(sys_sel),
    .edge_en(edge_en), .level_en(level_en), .pin_invert(pin_invert),
    .filt_en(filt_en), .filt_div(filt_div), .filt_thr(filt_thr),
    .sw_edge_req(sw_edge_req), .sw_level_req(sw_level_req),
    .edge_clr(edge_clr), .period_end(period_end),
    .edge_flag(edge_flag), .level_flag(level_flag),
    .brake_active(brake_active), .out_mask(out_mask), .brake_irq(brake_irq)
  );

  // {cmp[1:0], adc, sys_fail[3:0], sys_sel[3:0], edge_en[5:0], level_en[5:0], exp_edge, exp_level}
  localparam logic [24:0] VEC [8] = '{
    {2'b01, 1'b0, 4'b0000, 4'b0000, 6'b000001, 6'b000000, 1'b1, 1'b0},
    {2'b10, 1'b0, 4'b0000, 4'b0000, 6'b000000, 6'b000010, 1'b0, 1'b1},
    {2'b01, 1'b0, 4'b0000, 4'b0000, 6'b000010, 6'b000000, 1'b0, 1'b0},
    {2'b00, 1'b1, 4'b0000, 4'b0000, 6'b010000, 6'b010000, 1'b1, 1'b1},
    {2'b00, 1'b0, 4'b0010, 4'b0010, 6'b100000, 6'b000000, 1'b1, 1'b0},
    {2'b00, 1'b0, 4'b0010, 4'b0001, 6'b100000, 6'b100000, 1'b0, 1'b0},
    {2'b00, 1'b0, 4'b1000, 4'b1000, 6'b000000, 6'b100000, 1'b0, 1'b1},
    {2'b10, 1'b0, 4'b0000, 4'b0000, 6'b111101, 6'b111101, 1'b0, 1'b0}
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    cmp_in = '0; brk_pin = '0; adc_mon = 1'b0; sys_fail = '0; sys_sel = '0;
    edge_en = '0; level_en = '0; pin_invert = '0; filt_en = 1'b0;
    sw_edge_req = '0; sw_level_req = '0;
    edge_clr = '1; period_end = '1;
    step();
    edge_clr = '0; period_end = '0;
    step();
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(2);
    // R1: reset state
    chk("R1 flags", {edge_flag, level_flag, brake_active}, '0);
    chk("R1 mask/irq", {out_mask, brake_irq}, '0);
    rst_n = 1'b1;
    step();

    // vector table: R2 R5 R6 R4 R11
    for (int v = 0; v < 8; v++) begin
      clear_all();
      {cmp_in, adc_mon, sys_fail, sys_sel, edge_en, level_en} = VEC[v][24:2];
      step();
      chk($sformatf("R2/R5/R6 edge vec%0d", v), edge_flag, {NP{VEC[v][1]}});
      chk($sformatf("R4/R5/R6 level vec%0d", v), level_flag, {NP{VEC[v][0]}});
      chk($sformatf("R11 irq vec%0d", v), brake_irq, VEC[v][1] | VEC[v][0]);
    end

    // R2 hold after source drops, R10 mask, R11 single pulse
    clear_all();
    edge_en = 6'b000001; cmp_in = 2'b01;
    step();
    cmp_in = 2'b00;
    step();
    chk("R11 no repeat", brake_irq, 1'b0);
    step(4);
    chk("R2 hold", edge_flag, 3'b111);
    chk("R10 active", brake_active, 3'b111);
    chk("R10 mask", out_mask, 6'b111111);
    // R3 clear one pair
    edge_clr = 3'b010;
    step();
    edge_clr = '0;
    chk("R3 clear pair1", edge_flag, 3'b101);
    chk("R10 mask pair1", out_mask, 6'b110011);
    // R3 set wins over clear in the same cycle
    edge_clr = 3'b011; sw_edge_req = 3'b010;
    step();
    edge_clr = '0; sw_edge_req = '0;
    chk("R3 set wins", edge_flag, 3'b110);

    // R4 release only at period end
    clear_all();
    level_en = 6'b000001; cmp_in = 2'b01;
    step();
    chk("R4 level set", level_flag, 3'b111);
    chk("R5 level-only no edge", edge_flag, 3'b000);
    period_end = 3'b111;
    step();
    period_end = '0;
    chk("R4 held while active", level_flag, 3'b111);
    cmp_in = 2'b00;
    step(3);
    chk("R4 held no boundary", level_flag, 3'b111);
    period_end = 3'b001;
    step();
    period_end = '0;
    chk("R4 release pair0", level_flag, 3'b110);

    // R7 per-pair software requests
    clear_all();
    sw_level_req = 3'b010;
    step();
    sw_level_req = '0;
    chk("R7 level pair1", level_flag, 3'b010);
    sw_edge_req = 3'b100;
    step();
    sw_edge_req = '0;
    chk("R7 edge pair2", edge_flag, 3'b100);

    // R8 inversion, filter off
    clear_all();
    level_en = 6'b000100; pin_invert = 2'b01; brk_pin = 2'b00;
    step(2);
    chk("R8 inverted low pin active", level_flag, 3'b111);
    brk_pin = 2'b01;
    step(2);
    period_end = '1;
    step();
    period_end = '0;
    chk("R8 inverted high pin idle", level_flag, 3'b000);

    // R9 filter: divide by 4, three ticks
    clear_all();
    filt_en = 1'b1; filt_div = 3'd2; filt_thr = 4'd3; level_en = 6'b001000;
    step(4);
    brk_pin = 2'b10;
    step(6);
    brk_pin = 2'b00;
    step(30);
    chk("R9 glitch rejected", level_flag, 3'b000);
    brk_pin = 2'b10;
    step(40);
    chk("R9 steady accepted", level_flag, 3'b111);

    clear_all();
    chk("R1 idle after clear", {edge_flag, level_flag}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule